// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block keeps a free-running 32-bit time counter. It turns a set of capture sources into typed event records and queues them in a single FIFO for software to collect. The sources are a software push, counter wrap, counter half-wrap, four hardware push pins, and receive and transmit strobes. The receive and transmit strobes come with a port number, message type and sequence ID that were decoded upstream. Every record carries the timestamp of its source, the event kind, a port or pin number, the message type and the sequence ID.

Software works the unit through a word-addressed register file. It can enable the unit, load the counter and push a software event. It reads the oldest record through a low/high word pair and then discards it with a pop write. A level interrupt stays asserted while the FIFO holds anything, and it can also be forced for test. Sources that fire together are queued one per cycle in a fixed priority. A record that meets a full FIFO is lost, and this sets an overflow flag.

Top module: `evstamp_unit`

## Requirements
- R1: After reset, the control word reads 0, the raw and masked status read 0, `irq_o` and `ovf_o` are 0, and the event-high word reads 0.
- R2: Word 0 reads {16'h4E53, 5'd2, 3'd1, 8'h05}: identifier in bits 31:16, RTL version in 15:11, major in 10:8, minor in 7:0.
- R3: While control bit 0 is 1, the counter advances by one per cycle. Writing 1 to bit 0 of word 5 copies word 4 into the counter. A push in the cycle after a load records the loaded value.
- R4: Writing 1 to bit 0 of word 3 queues a record of kind 0 stamped with the counter value of that cycle. Word 13 returns the head timestamp. Word 14 returns the head as port[28:24], kind[23:20], message type[19:16] and sequence[15:0].
- R5: When the counter steps from all ones to zero, a record of kind 1 with timestamp 0 is queued. When bit 31 steps from 0 to 1, a record of kind 2 with timestamp 32'h80000000 is queued. Neither has port, message or sequence.
- R6: A rising edge on `hw_pin[k]` queues a kind 3 record with port k+1, but only when control bit 8+k is set. An edge on a pin whose bit is clear queues nothing.
- R7: A receive strobe queues kind 4 and a transmit strobe queues kind 5. Each carries the port, message type and sequence given with its strobe.
- R8: Sources that fire in the same cycle are queued over successive cycles in this order: software push, wrap, half-wrap, pins 1 to 4, receive, transmit.
- R9: A record reaching a full FIFO is dropped and sets `ovf_o`. A pop write clears `ovf_o`.
- R10: Writing 1 to bit 0 of word 12 discards the head record. A pop on an empty FIFO changes nothing. Words 13 and 14 read 0 when the FIFO is empty.
- R11: Raw status (word 8, bit 0) is FIFO non-empty OR control bit 1. Masked status (word 9) is raw AND bit 0 of word 10. `irq_o` equals masked status.
- R12: While control bit 0 is 0, the counter holds its value and no source queues a record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| hw_pin | input | 4 | Hardware push inputs, rising edge active |
| rx_stb | input | 1 | Receive event strobe |
| rx_port | input | 5 | Receive port number |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence ID |
| tx_stb | input | 1 | Transmit event strobe |
| tx_port | input | 5 | Transmit port number |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence ID |
| irq_o | output | 1 | Level interrupt (masked status) |
| ovf_o | output | 1 | Record-dropped flag |

## Verification
The bench builds the unit with a FIFO depth of 4 in place of 16. Six back-to-back pushes are then enough to fill the queue, drop two records and raise the overflow flag. Rollover and half-rollover are reached by loading the counter a few counts short of each boundary, so there is no wait of 2^31 cycles. All four pins, a receive strobe and the software push fire in one cycle to show the priority order.

// File: rtl/evstamp_pkg.sv
package evstamp_pkg;
  localparam int unsigned TS_W = 32;

  typedef struct packed {
    logic [4:0]      port;
    logic [3:0]      kind;
    logic [3:0]      msg;
    logic [15:0]     seq;
    logic [TS_W-1:0] ts;
  } ev_rec_t;

  localparam logic [3:0] KIND_PUSH = 4'd0;
  localparam logic [3:0] KIND_ROLL = 4'd1;
  localparam logic [3:0] KIND_HALF = 4'd2;
  localparam logic [3:0] KIND_PIN  = 4'd3;
  localparam logic [3:0] KIND_RX   = 4'd4;
  localparam logic [3:0] KIND_TX   = 4'd5;

  localparam logic [3:0] A_IDVER = 4'd0;
  localparam logic [3:0] A_CTRL  = 4'd1;
  localparam logic [3:0] A_PUSH  = 4'd3;
  localparam logic [3:0] A_LDVAL = 4'd4;
  localparam logic [3:0] A_LDEN  = 4'd5;
  localparam logic [3:0] A_RAW   = 4'd8;
  localparam logic [3:0] A_MASK  = 4'd9;
  localparam logic [3:0] A_INTEN = 4'd10;
  localparam logic [3:0] A_POP   = 4'd12;
  localparam logic [3:0] A_EVLO  = 4'd13;
  localparam logic [3:0] A_EVHI  = 4'd14;
endpackage

// File: rtl/evstamp_counter.sv
module evstamp_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         roll_fire,
  output logic         half_fire
);
  localparam logic [W-1:0] ALL_ONES  = {W{1'b1}};
  localparam logic [W-1:0] HALF_EDGE = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | run;
    cnt_d  = load ? load_val : cnt + 1'b1;
  end

  assign roll_fire = run & ~load & (cnt == ALL_ONES);
  assign half_fire = run & ~load & (cnt == HALF_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/evstamp_arb.sv
module evstamp_arb
  import evstamp_pkg::*;
#(
  parameter int unsigned NSRC = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     fire,
  input  ev_rec_t [NSRC-1:0]  rec_in,
  output logic                out_valid,
  output ev_rec_t             out_rec,
  output logic [NSRC-1:0]     grant,
  output logic                collide
);
  logic [NSRC-1:0]    pend, pend_d;
  ev_rec_t [NSRC-1:0] slot, slot_d;
  logic               found;

  always_comb begin
    grant   = '0;
    found   = 1'b0;
    out_rec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        out_rec  = slot[i];
      end
    end
    out_valid = found;
  end

  always_comb begin
    pend_d  = (pend & ~grant) | fire;
    slot_d  = slot;
    collide = |(fire & pend & ~grant);
    for (int i = 0; i < NSRC; i++) begin
      if (fire[i] && !(pend[i] && !grant[i])) slot_d[i] = rec_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      slot <= '0;
    end else begin
      pend <= pend_d;
      slot <= slot_d;
    end
  end
endmodule

// File: rtl/evstamp_fifo.sv
module evstamp_fifo
  import evstamp_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  ev_rec_t       wr_rec,
  input  logic          pop,
  output ev_rec_t       head,
  output logic          empty,
  output logic          full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  ev_rec_t        mem [DEPTH];
  logic [AW-1:0]  wp, rp, wp_d, rp_d;
  logic [CW-1:0]  count_d;
  logic           do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = empty ? '0 : mem[rp];

  always_comb begin
    do_wr   = push & ~full;
    do_rd   = pop & ~empty;
    wp_d    = do_wr ? ((wp == LAST) ? '0 : wp + 1'b1) : wp;
    rp_d    = do_rd ? ((rp == LAST) ? '0 : rp + 1'b1) : rp;
    count_d = count + CW'(do_wr) - CW'(do_rd);
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp_d;
      rp    <= rp_d;
      count <= count_d;
    end
  end
endmodule

// File: rtl/evstamp_unit.sv
module evstamp_unit
  import evstamp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned N_HW       = 4,
  parameter logic [15:0] ID_IDENT   = 16'h4E53,
  parameter logic [4:0]  ID_RTL     = 5'd2,
  parameter logic [2:0]  ID_MAJOR   = 3'd1,
  parameter logic [7:0]  ID_MINOR   = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  hw_pin,
  input  logic        rx_stb,
  input  logic [4:0]  rx_port,
  input  logic [3:0]  rx_msg,
  input  logic [15:0] rx_seq,
  input  logic        tx_stb,
  input  logic [4:0]  tx_port,
  input  logic [3:0]  tx_msg,
  input  logic [15:0] tx_seq,
  output logic        irq_o,
  output logic        ovf_o
);
  localparam int unsigned NSRC   = 5 + N_HW;
  localparam int unsigned IX_HW  = 3;
  localparam int unsigned IX_RX  = IX_HW + N_HW;
  localparam int unsigned IX_TX  = IX_RX + 1;
  localparam int unsigned CW     = $clog2(FIFO_DEPTH+1);

  // control and software-visible state
  logic            ctrl_en, ctrl_test, inten;
  logic [3:0]      ctrl_hw;
  logic [TS_W-1:0] ldval;
  logic            ovf_q, ovf_d;
  logic [3:0]      pin_prev;

  logic wr_ctrl, wr_push, wr_ldval, wr_lden, wr_inten, wr_pop;

  always_comb begin
    wr_ctrl  = reg_wr & (reg_addr == A_CTRL);
    wr_push  = reg_wr & (reg_addr == A_PUSH)  & reg_wdata[0];
    wr_ldval = reg_wr & (reg_addr == A_LDVAL);
    wr_lden  = reg_wr & (reg_addr == A_LDEN)  & reg_wdata[0];
    wr_inten = reg_wr & (reg_addr == A_INTEN);
    wr_pop   = reg_wr & (reg_addr == A_POP)   & reg_wdata[0];
  end

  // counter
  logic [TS_W-1:0] cnt;
  logic            roll_fire, half_fire;

  evstamp_counter #(.W(TS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .load(wr_lden),
    .load_val(ldval), .cnt(cnt), .roll_fire(roll_fire), .half_fire(half_fire)
  );

  // sources and their records
  logic [NSRC-1:0]    fire;
  ev_rec_t [NSRC-1:0] src_rec;

  always_comb begin
    fire = '0;
    src_rec = '0;
    fire[0] = ctrl_en & wr_push;
    src_rec[0].kind = KIND_PUSH;
    src_rec[0].ts   = cnt;
    fire[1] = roll_fire;
    src_rec[1].kind = KIND_ROLL;
    src_rec[1].ts   = cnt + 1'b1;
    fire[2] = half_fire;
    src_rec[2].kind = KIND_HALF;
    src_rec[2].ts   = cnt + 1'b1;
    fire[IX_RX] = ctrl_en & rx_stb;
    src_rec[IX_RX] = '{port: rx_port, kind: KIND_RX, msg: rx_msg, seq: rx_seq, ts: cnt};
    fire[IX_TX] = ctrl_en & tx_stb;
    src_rec[IX_TX] = '{port: tx_port, kind: KIND_TX, msg: tx_msg, seq: tx_seq, ts: cnt};
    for (int k = 0; k < N_HW; k++) begin
      fire[IX_HW+k]         = ctrl_en & ctrl_hw[k] & hw_pin[k] & ~pin_prev[k];
      src_rec[IX_HW+k].kind = KIND_PIN;
      src_rec[IX_HW+k].port = 5'(k + 1);
      src_rec[IX_HW+k].ts   = cnt;
    end
  end

  // arbitration and queue
  logic            arb_valid, collide;
  ev_rec_t         arb_rec, head;
  logic [NSRC-1:0] arb_grant;
  logic            fifo_empty, fifo_full;
  logic [CW-1:0]   fifo_count;

  evstamp_arb #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rec_in(src_rec),
    .out_valid(arb_valid), .out_rec(arb_rec), .grant(arb_grant), .collide(collide)
  );

  evstamp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(arb_valid), .wr_rec(arb_rec),
    .pop(wr_pop), .head(head), .empty(fifo_empty), .full(fifo_full),
    .count(fifo_count)
  );

  // overflow flag: set wins over clear
  always_comb begin
    ovf_d = ovf_q;
    if (wr_pop) ovf_d = 1'b0;
    if ((arb_valid & fifo_full) | collide) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_test <= 1'b0;
      ctrl_hw   <= '0;
      inten     <= 1'b0;
      ldval     <= '0;
      ovf_q     <= 1'b0;
      pin_prev  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en   <= reg_wdata[0];
        ctrl_test <= reg_wdata[1];
        ctrl_hw   <= reg_wdata[11:8];
      end
      if (wr_inten) inten <= reg_wdata[0];
      if (wr_ldval) ldval <= reg_wdata;
      ovf_q    <= ovf_d;
      pin_prev <= hw_pin;
    end
  end

  // interrupt and read mux
  logic raw_pend, mask_pend;
  assign raw_pend  = ~fifo_empty | ctrl_test;
  assign mask_pend = raw_pend & inten;
  assign irq_o     = mask_pend;
  assign ovf_o     = ovf_q;

  always_comb begin
    unique case (reg_addr)
      A_IDVER: reg_rdata = {ID_IDENT, ID_RTL, ID_MAJOR, ID_MINOR};
      A_CTRL:  reg_rdata = {20'd0, ctrl_hw, 6'd0, ctrl_test, ctrl_en};
      A_LDVAL: reg_rdata = ldval;
      A_RAW:   reg_rdata = {31'd0, raw_pend};
      A_MASK:  reg_rdata = {31'd0, mask_pend};
      A_INTEN: reg_rdata = {31'd0, inten};
      A_EVLO:  reg_rdata = head.ts;
      A_EVHI:  reg_rdata = {3'd0, head.port, head.kind, head.msg, head.seq};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evstamp_checker.sv
module evstamp_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NSRC  = 9,
  parameter int unsigned CW    = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arb_valid,
  input logic            fifo_full,
  input logic            fifo_empty,
  input logic [CW-1:0]   fifo_count,
  input logic [NSRC-1:0] arb_grant,
  input logic            ovf_q,
  input logic            run,
  input logic            load,
  input logic [31:0]     cnt,
  input logic            test_bit,
  input logic            irq_o
);
  assert_ovf_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_valid && fifo_full) |=> ovf_q);

  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_grant));

  assert_hold_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !test_bit) |-> !irq_o);
endmodule

bind evstamp_unit evstamp_checker #(
  .DEPTH(FIFO_DEPTH), .NSRC(NSRC), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arb_valid(arb_valid), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .fifo_count(fifo_count), .arb_grant(arb_grant),
  .ovf_q(ovf_q), .run(ctrl_en), .load(wr_lden), .cnt(cnt),
  .test_bit(ctrl_test), .irq_o(irq_o)
);

// File: tb/evstamp_unit_bench.sv
module evstamp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  hw_pin = '0;
  logic        rx_stb = 1'b0, tx_stb = 1'b0;
  logic [4:0]  rx_port = '0, tx_port = '0;
  logic [3:0]  rx_msg = '0, tx_msg = '0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic        irq_o, ovf_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evstamp_unit #(.FIFO_DEPTH(4)) u_evstamp_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_pin(hw_pin),
    .rx_stb(rx_stb), .rx_port(rx_port), .rx_msg(rx_msg), .rx_seq(rx_seq),
    .tx_stb(tx_stb), .tx_port(tx_port), .tx_msg(tx_msg), .tx_seq(tx_seq),
    .irq_o(irq_o), .ovf_o(ovf_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic take(output logic [31:0] lo, output logic [31:0] hi);
    repeat (3) @(negedge clk);
    rd(4'd13, lo);
    rd(4'd14, hi);
    wr(4'd12, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd1, v);  check("R1 ctrl", v, 0);
    rd(4'd8, v);  check("R1 raw", v, 0);
    rd(4'd9, v);  check("R1 masked", v, 0);
    rd(4'd14, v); check("R1 evhi", v, 0);
    check("R1 irq", {31'd0, irq_o}, 0);
    check("R1 ovf", {31'd0, ovf_o}, 0);
  endtask

  task automatic t_id;
    logic [31:0] v;
    rd(4'd0, v);
    check("R2 idver", v, {16'h4E53, 5'd2, 3'd1, 8'h05});
  endtask

  task automatic t_count_load;
    logic [31:0] lo1, hi1, lo2, hi2;
    wr(4'd1, 32'd1);
    wr(4'd3, 32'd1);
    repeat (5) @(negedge clk);
    wr(4'd3, 32'd1);
    take(lo1, hi1); take(lo2, hi2);
    check("R3 advance", lo2 - lo1, 32'd6);
    check("R4 push kind", hi1, 32'h0);
    wr(4'd4, 32'h1234_5678);
    wr(4'd5, 32'd1);
    wr(4'd3, 32'd1);
    take(lo1, hi1);
    check("R3 load", lo1, 32'h1234_5678);
    check("R4 push evhi", hi1, 32'h0);
  endtask

  task automatic t_disable;
    logic [31:0] lo1, hi1, lo2, hi2, v;
    wr(4'd3, 32'd1);
    wr(4'd1, 32'd0);
    repeat (10) @(negedge clk);
    wr(4'd3, 32'd1);
    rx_stb = 1'b1; @(negedge clk); rx_stb = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd8, v);
    take(lo1, hi1);
    rd(4'd8, v); check("R12 none queued", v, 32'd0);
    wr(4'd1, 32'd1);
    wr(4'd3, 32'd1);
    take(lo2, hi2);
    check("R12 counter held", lo2 - lo1, 32'd2);
  endtask

  task automatic t_wrap;
    logic [31:0] lo, hi, v;
    wr(4'd4, 32'hFFFF_FFFD);
    wr(4'd5, 32'd1);
    repeat (6) @(negedge clk);
    take(lo, hi);
    check("R5 roll evhi", hi, 32'h0010_0000);
    check("R5 roll ts", lo, 32'h0);
    rd(4'd8, v); check("R5 roll single", v, 32'd0);
    wr(4'd4, 32'h7FFF_FFFD);
    wr(4'd5, 32'd1);
    repeat (6) @(negedge clk);
    take(lo, hi);
    check("R5 half evhi", hi, 32'h0020_0000);
    check("R5 half ts", lo, 32'h8000_0000);
  endtask

  task automatic t_priority;
    logic [31:0] lo[4], hi[4], v;
    wr(4'd1, 32'h0000_0501);            // pins 1 and 3 enabled
    rx_port = 5'd5; rx_msg = 4'd3; rx_seq = 16'hBEEF;
    hw_pin = 4'b1111; rx_stb = 1'b1;
    wr(4'd3, 32'd1);
    hw_pin = 4'b0000; rx_stb = 1'b0;
    for (int i = 0; i < 4; i++) take(lo[i], hi[i]);
    check("R8 first push", hi[0], 32'h0000_0000);
    check("R6 pin1", hi[1], 32'h0130_0000);
    check("R6 pin3", hi[2], 32'h0330_0000);
    check("R7 rx", hi[3], 32'h0543_BEEF);
    check("R8 same stamp", lo[3], lo[0]);
    rd(4'd8, v); check("R6 pins 2,4 ignored", v, 32'd0);
    tx_port = 5'd2; tx_msg = 4'hA; tx_seq = 16'h1234; tx_stb = 1'b1;
    @(negedge clk); tx_stb = 1'b0;
    take(lo[0], hi[0]);
    check("R7 tx", hi[0], 32'h025A_1234);
  endtask

  task automatic t_full;
    logic [31:0] lo, hi, first;
    for (int i = 0; i < 6; i++) wr(4'd3, 32'd1);
    repeat (2) @(negedge clk);
    check("R9 ovf set", {31'd0, ovf_o}, 32'd1);
    rd(4'd13, first);
    take(lo, hi);
    check("R9 pop clears ovf", {31'd0, ovf_o}, 32'd0);
    for (int i = 1; i < 4; i++) begin
      take(lo, hi);
      check("R9 kept order", lo - first, 32'(i));
    end
    rd(4'd8, lo); check("R9 two dropped", lo, 32'd0);
  endtask

  task automatic t_pop_empty;
    logic [31:0] lo, hi, v;
    wr(4'd12, 32'd1);
    rd(4'd8, v);  check("R10 empty pop raw", v, 32'd0);
    rd(4'd13, v); check("R10 empty evlo", v, 32'd0);
    wr(4'd4, 32'h0000_0100);
    wr(4'd5, 32'd1);
    wr(4'd3, 32'd1);
    wr(4'd3, 32'd1);
    repeat (3) @(negedge clk);
    rd(4'd13, lo); check("R10 head", lo, 32'h100);
    wr(4'd12, 32'd1);
    rd(4'd13, lo); check("R10 pop advances", lo, 32'h101);
    wr(4'd12, 32'd1);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(4'd10, 32'd0);
    wr(4'd1, 32'd3);
    rd(4'd8, v); check("R11 test raw", v, 32'd1);
    rd(4'd9, v); check("R11 masked off", v, 32'd0);
    check("R11 irq off", {31'd0, irq_o}, 32'd0);
    wr(4'd10, 32'd1);
    rd(4'd9, v); check("R11 masked on", v, 32'd1);
    check("R11 irq on", {31'd0, irq_o}, 32'd1);
    wr(4'd1, 32'd1);
    check("R11 irq empty", {31'd0, irq_o}, 32'd0);
    wr(4'd3, 32'd1);
    repeat (3) @(negedge clk);
    check("R11 irq nonempty", {31'd0, irq_o}, 32'd1);
    wr(4'd12, 32'd1);
    check("R11 irq drained", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id();
    t_count_load();
    t_disable();
    t_wrap();
    t_priority();
    t_full();
    t_pop_empty();
    t_irq();
    finish_run();
  end
endmodule